// File: doc/BRIEF.md
# Compressor-Tree Vertical-Crosswise Multiplier

This block multiplies two unsigned 8-bit operands and returns a 16-bit product one clock after the operands are presented. Each operand bit pair `a[i] & b[j]` is a partial-product bit of weight `i+j`. Partial products are organised as shifted rows, so column `k` of the matrix holds exactly the bits whose indices add up to `k`. This is the vertical-and-crosswise view of multiplication.

The matrix is reduced in layers of 5:3 compressors. Each compressor takes four bits of its column plus a carry-in. That carry-in is the carry-out of the compressor one column lower in the same chain. Each compressor returns a sum bit for its own column, plus a carry bit and a carry-out for the next column. Each layer turns four rows into two. When two rows remain, a ripple adder forms the product. The product and a valid flag are then registered.

A parameter chooses how each compressor is built. Style 0 uses two cascaded full adders. Style 1 uses XOR gates and 2:1 multiplexers for a shorter path. Both styles compute the same function bit for bit.

Top module: `vcm_mult`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `p` equals the unsigned product of the `a` and `b` sampled in that cycle, for every one of the 65,536 operand pairs.
- R2: Every 5:3 compressor satisfies x1+x2+x3+x4+cin = sum + 2·(carry + cout). Here sum has the weight of its own column, and carry and cout have the weight of the next column.
- R3: Within a compressor layer, the carry-in of column k is the carry-out of column k−1, and column 0 receives 0. Each layer conserves the numeric total of its four input rows in its two output rows, where the outputs include the carries leaving the top column.
- R4: Partial-product bit `a[i] & b[j]` enters column i+j. A product of single-set-bit operands 2^i·2^j therefore gives exactly bit i+j of `p` set, for all i, j in 0..7.
- R5: `COMP_STYLE` = 0 selects the two-full-adder compressor and `COMP_STYLE` = 1 selects the XOR/multiplexer compressor. Both give identical `p` for all operand pairs.
- R6: `out_valid` equals the `in_valid` of the previous cycle. A synchronous active-high `rst` clears `out_valid` and `p` to 0 at the next clock edge.
- R7: In a cycle with `in_valid` low, `p` keeps its previous value at the next edge.
- R8: Zero times any operand gives 0, and 255 × 255 gives 65025.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `a` and `b` are to be multiplied |
| a | input | 8 | Unsigned multiplicand |
| b | input | 8 | Unsigned multiplier |
| out_valid | output | 1 | `p` holds a product captured at the previous edge |
| p | output | 16 | Registered unsigned product |

## Verification
All 65,536 operand pairs are streamed back to back through two copies of the block, one per compressor style. Each result is compared with the arithmetic product, and the two copies are compared with each other. A mismatch in any compressor chain, any column wiring or either style shows up here. Single-set-bit operand pairs place exactly one bit in one column, so a partial product routed to the wrong column is told apart from a reduction fault. The zero and all-ones operands exercise the empty and the fullest column loads. Further sequences separate the hold behaviour with `in_valid` low from a reset that arrives while new operands are waiting.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

  // Compressor implementation selectors
  localparam int COMP_FA   = 0;  // two cascaded full adders
  localparam int COMP_XMUX = 1;  // XOR / 2:1 multiplexer form

  // Outputs of one 5:3 compressor
  typedef struct packed {
    logic sum;    // weight of own column
    logic carry;  // weight of next column, to next layer
    logic cout;   // weight of next column, to neighbour's cin
  } c53_out_t;

  // One-bit full adder, returns {carry, sum}
  function automatic logic [1:0] full_add(input logic x, input logic y, input logic z);
    return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
  endfunction

endpackage

// File: rtl/vcm_comp53.sv
module vcm_comp53
  import vcm_pkg::*;
#(
  parameter int STYLE = COMP_FA
) (
  input  logic [3:0] x,
  input  logic       cin,
  output c53_out_t   y
);

  logic s_o, c_o, co_o;

  generate
    if (STYLE == COMP_FA) begin : g_fa
      logic s1;
      // first adder folds x[0..2]; its carry leaves sideways as cout
      assign {co_o, s1}  = full_add(x[0], x[1], x[2]);
      // second adder merges the partial sum, x[3] and the neighbour carry
      assign {c_o, s_o}  = full_add(s1, x[3], cin);
    end else begin : g_xmux
      logic p01, t;
      assign p01  = x[0] ^ x[1];
      assign t    = p01 ^ x[2] ^ x[3];
      assign s_o  = t ^ cin;
      assign co_o = p01 ? x[2] : x[0];
      assign c_o  = t ? cin : x[3];
    end
  endgenerate

  assign y = '{sum: s_o, carry: c_o, cout: co_o};

  // R2: weight conservation of a single compressor
  always_comb begin
    if (!$isunknown({x, cin, s_o, c_o, co_o})) begin
      assert_comp_weight_R2: assert ($countones({x, cin}) ==
                                     int'(s_o) + 2 * (int'(c_o) + int'(co_o)));
    end
  end

endmodule

// File: rtl/vcm_ppgen.sv
module vcm_ppgen #(
  parameter int W = 8
) (
  input  logic [W-1:0]            a,
  input  logic [W-1:0]            b,
  output logic [W-1:0][2*W-1:0]   rows
);

  localparam int P = 2 * W;

  // Row i carries a[k-i] & b[i] in column k, so column k collects every
  // bit pair whose indices sum to k.
  generate
    for (genvar i = 0; i < W; i++) begin : g_row
      assign rows[i] = P'(a & {W{b[i]}}) << i;
    end
  endgenerate

endmodule

// File: rtl/vcm_comp_row.sv
module vcm_comp_row
  import vcm_pkg::*;
#(
  parameter int W     = 16,
  parameter int STYLE = COMP_FA
) (
  input  logic [W-1:0] r0,
  input  logic [W-1:0] r1,
  input  logic [W-1:0] r2,
  input  logic [W-1:0] r3,
  output logic [W-1:0] s_vec,
  output logic [W-1:0] c_vec
);

  localparam int TW = W + 2;

  logic [W-1:0] cout_v;
  logic [W-1:0] carry_v;

  generate
    for (genvar k = 0; k < W; k++) begin : g_col
      logic     cin_k;
      c53_out_t y_k;
      if (k == 0) begin : g_first
        assign cin_k = 1'b0;
      end else begin : g_chain
        assign cin_k = cout_v[k-1];
      end
      vcm_comp53 #(.STYLE(STYLE)) u_c53 (
        .x   ({r3[k], r2[k], r1[k], r0[k]}),
        .cin (cin_k),
        .y   (y_k)
      );
      assign s_vec[k]   = y_k.sum;
      assign carry_v[k] = y_k.carry;
      assign cout_v[k]  = y_k.cout;
    end
  endgenerate

  // carries move one column up into the second output row
  assign c_vec = {carry_v[W-2:0], 1'b0};

  // R3: layer keeps the numeric total, counting carries that leave the top
  logic [TW-1:0] in_tot, out_tot;
  assign in_tot  = TW'(r0) + TW'(r1) + TW'(r2) + TW'(r3);
  assign out_tot = TW'(s_vec) + TW'(c_vec) +
                   (TW'(carry_v[W-1]) << W) + (TW'(cout_v[W-1]) << W);

  always_comb begin
    if (!$isunknown({in_tot, out_tot})) begin
      assert_layer_total_R3: assert (in_tot == out_tot);
    end
  end

endmodule

// File: rtl/vcm_cpa.sv
module vcm_cpa
  import vcm_pkg::*;
#(
  parameter int P = 16
) (
  input  logic [P-1:0] x,
  input  logic [P-1:0] y,
  output logic [P-1:0] s
);

  logic [P-1:0] c;  // carry into column k

  assign c[0] = 1'b0;

  generate
    for (genvar k = 0; k < P; k++) begin : g_col
      if (k < P - 1) begin : g_mid
        assign {c[k+1], s[k]} = full_add(x[k], y[k], c[k]);
      end else begin : g_top
        assign s[k] = x[k] ^ y[k] ^ c[k];
      end
    end
  endgenerate

endmodule

// File: rtl/vcm_mult.sv
module vcm_mult
  import vcm_pkg::*;
#(
  parameter int W          = 8,        // operand width, power of two, >= 4
  parameter int COMP_STYLE = COMP_FA   // 0: full-adder compressor, 1: XOR/mux
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output logic              out_valid,
  output logic [2*W-1:0]    p
);

  localparam int P   = 2 * W;
  localparam int NST = $clog2(W) - 1;  // compressor layers, 4 rows -> 2 each
  localparam int TOT = 2 * W - 2;      // rows over all levels

  // Flat row store: level s starts at 2W - 2*(W >> s)
  logic [TOT-1:0][P-1:0] tree;
  logic [P-1:0]          prod_c;

  vcm_ppgen #(.W(W)) u_pp (
    .a    (a),
    .b    (b),
    .rows (tree[W-1:0])
  );

  generate
    for (genvar s = 1; s <= NST; s++) begin : g_stage
      localparam int IN_OFF  = 2 * W - 2 * (W >> (s - 1));
      localparam int OUT_OFF = 2 * W - 2 * (W >> s);
      localparam int NGRP    = (W >> (s - 1)) / 4;
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
        vcm_comp_row #(.W(P), .STYLE(COMP_STYLE)) u_row (
          .r0    (tree[IN_OFF + 4*g]),
          .r1    (tree[IN_OFF + 4*g + 1]),
          .r2    (tree[IN_OFF + 4*g + 2]),
          .r3    (tree[IN_OFF + 4*g + 3]),
          .s_vec (tree[OUT_OFF + 2*g]),
          .c_vec (tree[OUT_OFF + 2*g + 1])
        );
      end
    end
  endgenerate

  vcm_cpa #(.P(P)) u_cpa (
    .x (tree[TOT-2]),
    .y (tree[TOT-1]),
    .s (prod_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      p         <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) p <= prod_c;
    end
  end

  // R1: registered product matches arithmetic product of sampled operands
  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (p == P'($past(a)) * P'($past(b))));

  // R6: valid follows one cycle later
  assert_valid_hi_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_lo_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R6: reset clears both outputs
  assert_reset_clear_R6: assert property (@(posedge clk)
    rst |=> (!out_valid && p == '0));

  // R7: idle cycles keep the product
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(p));

endmodule

// File: tb/sim_vcm_mult.sv
`timescale 1ns/1ps
module sim_vcm_mult;

  localparam int W = 8;
  localparam int P = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         ov0, ov1;
  logic [P-1:0] p0, p1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vcm_mult #(.W(W), .COMP_STYLE(0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(ov0), .p(p0));

  vcm_mult #(.W(W), .COMP_STYLE(1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(ov1), .p(p1));

  task automatic check(input string req, input logic [P-1:0] got, input logic [P-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // drive one operand pair, then check both styles one edge later
  task automatic apply(input string req, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [P-1:0] e;
    e = P'(x) * P'(y);
    a = x; b = y; in_valid = 1'b1;
    @(negedge clk);
    check({req, " style0 product"}, p0, e);
    check({req, " style1 product"}, p1, e);
    check({req, " valid"}, P'(ov0 & ov1), P'(1));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6 reset out_valid u0", P'(ov0), '0);
    check("R6 reset out_valid u1", P'(ov1), '0);
    check("R6 reset p u0", p0, '0);
    check("R6 reset p u1", p1, '0);
    rst = 1'b0;
    @(negedge clk);

    // R8: corner operands
    apply("R8 zero times 173", 8'd0, 8'd173);
    apply("R8 91 times zero", 8'd91, 8'd0);
    apply("R8 all ones", 8'd255, 8'd255);
    check("R8 255x255 value", p0, 16'd65025);

    // R4: single set bits land in column i+j
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        apply("R4 single bits", 8'(1 << i), 8'(1 << j));
        check("R4 column position", p1, 16'(1 << (i + j)));
      end
    end

    // R7: hold while idle, operands changing underneath
    apply("R7 setup", 8'd200, 8'd3);
    in_valid = 1'b0; a = 8'd17; b = 8'd99;
    @(negedge clk);
    check("R7 hold u0", p0, 16'd600);
    check("R7 hold u1", p1, 16'd600);
    check("R6 valid drop u0", P'(ov0), '0);
    check("R6 valid drop u1", P'(ov1), '0);
    @(negedge clk);
    check("R7 hold second cycle", p0, 16'd600);

    // R6: reset wins over a pending operand pair
    apply("R6 before reset", 8'd12, 8'd12);
    rst = 1'b1; in_valid = 1'b1; a = 8'd5; b = 8'd5;
    @(negedge clk);
    check("R6 mid reset p u0", p0, '0);
    check("R6 mid reset p u1", p1, '0);
    check("R6 mid reset valid", P'(ov0 | ov1), '0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    // R1 R2 R3 R5: exhaustive back-to-back sweep, styles cross-checked
    for (int n = 0; n < 65536; n++) begin
      logic [P-1:0] e;
      a = n[15:8]; b = n[7:0]; in_valid = 1'b1;
      e = P'(a) * P'(b);
      @(negedge clk);
      check("R1 R2 R3 exhaustive style0", p0, e);
      check("R5 style1 equals style0", p1, p0);
    end
    check("R6 valid during sweep", P'(ov0 & ov1), P'(1));
    in_valid = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule